// File: doc/BRIEF.md
# DSP Status Flags and Shadow Banks

This block keeps the arithmetic condition flags and the operating mode bits of a 16-bit signal processor core. Software and the instruction sequencer see this state through five 16-bit status views. The views overlap and lay the same state out differently. Each view has its own rules for reading and writing. One view folds two saturation-related flags into a single bit. Two views carry the 4-bit extension nibble of an accumulator, and a write to that nibble sign-extends into the accumulator's upper bits.

Two context mechanisms support fast interrupt entry. A store pulse copies the ten flags into a flag shadow, and a restore pulse copies them back. A swap pulse exchanges the whole mode set with a second bank. The block also decodes a 4-bit branch condition code against the live flags and the user input pins, and reports whether the condition passes.

Reads are combinational from the view selected by `view_sel`. A write with `wr_req` takes effect at the next rising clock edge.

Top module: `dspst_status_top`

## Requirements
- R1: After reset all flags, both shadow banks and both accumulator extensions are zero, and the live mode set is zero except the move-to-accumulator saturation bit and the step method bit, which are 1. Control view 3 therefore reads 0x0028 with the pending and user inputs low.
- R2: Flag view 0 maps zero, minus, normalized, overflow, extension, carry0, carry1, saturation-latch, latching-overflow and address-zero to bits 0 through 9 in that order, for both read and write. Bits 15:10 read 0.
- R3: Summary view 1 has zero, minus, normalized, overflow and carry0 in bits 0 to 4, extension in bit 6, address-zero in bit 7, the saturation-disable mode in bit 8 and the three interrupt enables in bits 11:9. Bit 5 reads as saturation-latch OR latching-overflow, and a write to bit 5 sets both flags to the written value. A write to view 1 leaves carry1 unchanged.
- R4: Bits 15:12 of view 1 hold accumulator 0's extension nibble, and bits 15:12 of view 2 hold accumulator 1's. A write loads the nibble into the accumulator's low extension bits and copies nibble bit 3 into every bit above it.
- R5: In view 3, bits 10 and 11 show user inputs 0 and 1, and bits 13, 14 and 15 show pending interrupts 2, 0 and 1. These fields are read-only, and writes to them have no effect.
- R6: Reserved bits read 0. Views 5 to 7 read 0, and a write to them changes no state.
- R7: A store pulse copies the ten live flags into the flag shadow.
- R8: A restore pulse loads the live flags from the flag shadow. It takes priority over a same-cycle flag write, and it leaves the shadow unchanged. If store and restore come in the same cycle, the shadow takes the old live flags and the live flags take the old shadow.
- R9: A swap pulse exchanges the whole live mode set with its shadow bank. A mode write in the same cycle is dropped.
- R10: Swap and store/restore pulses in the same cycle each act on their own set, and neither blocks the other.
- R11: The condition output decodes codes 0 to 15 as: always, zero, not zero, greater (zero and minus both clear), greater-or-equal (minus clear), less (minus set), less-or-equal (minus or zero set), not normalized, carry0, overflow, extension, limit (saturation-latch or latching-overflow), address-zero clear, user input 0 low, user input 0 high, user input 1 high.
- R12: View 2 holds page in bits 7:0, product shift 0 in bits 9:8 and shift mode in bit 10. View 3 holds half-word mode in bits 1:0, the two saturation bits in bits 2 and 3, the 16-bit step bit in bit 4, the step method bit in bit 5, the two end-of-buffer bits in bits 6 and 7, and product shift 1 in bits 9:8. View 4 holds the modulo enables in bits 7:0 and the bit-reverse enables in bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| view_sel | input | 3 | Status view to read and write |
| wr_req | input | 1 | Write wr_data into the selected view |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational contents of the selected view |
| store_req | input | 1 | Copy live flags into the flag shadow |
| restore_req | input | 1 | Copy flag shadow into live flags |
| swap_req | input | 1 | Exchange live mode set with its shadow bank |
| irq_pend | input | 3 | Pending interrupt lines (read-only in view 3) |
| user_in | input | 2 | User input pins (read-only in view 3, used by conditions) |
| cond_sel | input | 4 | Condition code to evaluate |
| cond_pass | output | 1 | Selected condition holds |
| acc0_ext | output | ACC_EXT_W | Accumulator 0 bits above bit 31 |
| acc1_ext | output | ACC_EXT_W | Accumulator 1 bits above bit 31 |

## Verification
The hardest cases to reach are pulse collisions: store and restore together, swap together with a mode write, and swap together with a flag-context pulse. Random traffic with sparse pulses almost never lines these up with a known shadow content. Directed sequences therefore first load the shadows with distinct patterns and then fire the colliding pulses. Reads through the views show whether each set moved as required. Around these directed steps, random writes to all eight views, random pulses and random condition codes are checked against a bench model.

// File: rtl/dspst_pkg.sv
package dspst_pkg;

  localparam int DATA_W  = 16;
  localparam int NIB_W   = 4;
  localparam int NUM_AR  = 8;
  localparam int PAGE_W  = 8;
  localparam int NUM_IRQ = 3;
  localparam int NUM_UIN = 2;

  typedef enum logic [2:0] {
    V_FLAGS   = 3'd0,
    V_SUMMARY = 3'd1,
    V_PAGE    = 3'd2,
    V_CTRL    = 3'd3,
    V_ADDR    = 3'd4,
    V_RSV5    = 3'd5,
    V_RSV6    = 3'd6,
    V_RSV7    = 3'd7
  } view_e;

  // first member is the MSB: zero lands at bit 0
  typedef struct packed {
    logic arz;
    logic lovf;
    logic slat;
    logic c1;
    logic c0;
    logic ext;
    logic ovf;
    logic norm;
    logic minus;
    logic zero;
  } flags_t;

  typedef struct packed {
    logic [NUM_IRQ-1:0] imen;
    logic [NUM_AR-1:0]  bitrev;
    logic [NUM_AR-1:0]  modulo;
    logic               epj;
    logic               epi;
    logic               cmd;
    logic               stp16;
    logic [PAGE_W-1:0]  page;
    logic [1:0]         ps1;
    logic [1:0]         ps0;
    logic               shm;
    logic [1:0]         hwm;
    logic               sata;
    logic               sat;
  } modes_t;

  localparam int MODE_W = $bits(modes_t);

  function automatic modes_t mode_reset_val();
    modes_t m;
    m      = '0;
    m.sata = 1'b1;
    m.cmd  = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] view_read(
    view_e v, flags_t f, modes_t m,
    logic [NIB_W-1:0] n0, logic [NIB_W-1:0] n1,
    logic [NUM_IRQ-1:0] pend, logic [NUM_UIN-1:0] uin);
    logic [DATA_W-1:0] r;
    case (v)
      V_FLAGS:   r = {6'b0, f};
      V_SUMMARY: r = {n0, m.imen, m.sat, f.arz, f.ext, f.slat | f.lovf,
                      f.c0, f.ovf, f.norm, f.minus, f.zero};
      V_PAGE:    r = {n1, 1'b0, m.shm, m.ps0, m.page};
      V_CTRL:    r = {pend[1], pend[0], pend[2], 1'b0, uin[1], uin[0], m.ps1,
                      m.epj, m.epi, m.cmd, m.stp16, m.sata, m.sat, m.hwm};
      V_ADDR:    r = {m.bitrev, m.modulo};
      default:   r = '0;
    endcase
    return r;
  endfunction

  function automatic logic view_hits_flags(view_e v);
    return (v == V_FLAGS) || (v == V_SUMMARY);
  endfunction

  function automatic logic view_hits_modes(view_e v);
    return (v == V_SUMMARY) || (v == V_PAGE) || (v == V_CTRL) || (v == V_ADDR);
  endfunction

  function automatic flags_t flags_after_write(view_e v, logic [DATA_W-1:0] d, flags_t f);
    flags_t n;
    n = f;
    if (v == V_FLAGS) begin
      n = flags_t'(d[9:0]);
    end else if (v == V_SUMMARY) begin
      n.zero  = d[0];
      n.minus = d[1];
      n.norm  = d[2];
      n.ovf   = d[3];
      n.c0    = d[4];
      n.slat  = d[5];
      n.lovf  = d[5];
      n.ext   = d[6];
      n.arz   = d[7];
    end
    return n;
  endfunction

  function automatic modes_t modes_after_write(view_e v, logic [DATA_W-1:0] d, modes_t m);
    modes_t n;
    n = m;
    case (v)
      V_SUMMARY: begin
        n.sat  = d[8];
        n.imen = d[11:9];
      end
      V_PAGE: begin
        n.page = d[7:0];
        n.ps0  = d[9:8];
        n.shm  = d[10];
      end
      V_CTRL: begin
        n.hwm   = d[1:0];
        n.sat   = d[2];
        n.sata  = d[3];
        n.stp16 = d[4];
        n.cmd   = d[5];
        n.epi   = d[6];
        n.epj   = d[7];
        n.ps1   = d[9:8];
      end
      V_ADDR: begin
        n.modulo = d[7:0];
        n.bitrev = d[15:8];
      end
      default: n = m;
    endcase
    return n;
  endfunction

  function automatic logic cond_check(logic [3:0] c, flags_t f, logic [NUM_UIN-1:0] uin);
    logic p;
    case (c)
      4'd0:    p = 1'b1;
      4'd1:    p = f.zero;
      4'd2:    p = !f.zero;
      4'd3:    p = !f.zero && !f.minus;
      4'd4:    p = !f.minus;
      4'd5:    p = f.minus;
      4'd6:    p = f.minus || f.zero;
      4'd7:    p = !f.norm;
      4'd8:    p = f.c0;
      4'd9:    p = f.ovf;
      4'd10:   p = f.ext;
      4'd11:   p = f.slat || f.lovf;
      4'd12:   p = !f.arz;
      4'd13:   p = !uin[0];
      4'd14:   p = uin[0];
      default: p = uin[1];
    endcase
    return p;
  endfunction

endpackage

// File: rtl/dspst_flag_bank.sv
module dspst_flag_bank
  import dspst_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  flags_t wr_val,
  input  logic   store,
  input  logic   restore,
  output flags_t live,
  output flags_t shadow
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live   <= '0;
      shadow <= '0;
    end else begin
      if (restore)    live <= shadow;
      else if (wr_en) live <= wr_val;
      if (store)      shadow <= live;
    end
  end

endmodule

// File: rtl/dspst_mode_bank.sv
module dspst_mode_bank
  import dspst_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  modes_t wr_val,
  input  logic   swap,
  output modes_t live,
  output modes_t shadow
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live   <= mode_reset_val();
      shadow <= '0;
    end else if (swap) begin
      live   <= shadow;
      shadow <= live;
    end else if (wr_en) begin
      live <= wr_val;
    end
  end

endmodule

// File: rtl/dspst_acc_ext.sv
module dspst_acc_ext #(
  parameter int NUM_ACC = 2,
  parameter int EXT_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_ACC-1:0]       wr_en,
  input  logic [3:0]               nib,
  output logic [NUM_ACC*EXT_W-1:0] ext_flat
);

  localparam int SX_W = EXT_W - 4;

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    logic [EXT_W-1:0] ext_q;
    always_ff @(posedge clk) begin
      if (!rst_n)        ext_q <= '0;
      else if (wr_en[g]) ext_q <= {{SX_W{nib[3]}}, nib};
    end
    assign ext_flat[g*EXT_W +: EXT_W] = ext_q;
  end

endmodule

// File: rtl/dspst_view_port.sv
module dspst_view_port
  import dspst_pkg::*;
(
  input  view_e              view,
  input  logic               wr_req,
  input  logic [DATA_W-1:0]  wr_data,
  input  flags_t             flags,
  input  modes_t             modes,
  input  logic [NIB_W-1:0]   nib0,
  input  logic [NIB_W-1:0]   nib1,
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_UIN-1:0] uin,
  output logic [DATA_W-1:0]  rd_data,
  output logic               flag_wr_en,
  output flags_t             flag_next,
  output logic               mode_wr_en,
  output modes_t             mode_next,
  output logic [1:0]         acc_wr_en,
  output logic [NIB_W-1:0]   acc_nib
);

  always_comb begin
    rd_data      = view_read(view, flags, modes, nib0, nib1, pend, uin);
    flag_wr_en   = wr_req && view_hits_flags(view);
    mode_wr_en   = wr_req && view_hits_modes(view);
    flag_next    = flags_after_write(view, wr_data, flags);
    mode_next    = modes_after_write(view, wr_data, modes);
    acc_wr_en[0] = wr_req && (view == V_SUMMARY);
    acc_wr_en[1] = wr_req && (view == V_PAGE);
    acc_nib      = wr_data[15:12];
  end

endmodule

// File: rtl/dspst_status_top.sv
module dspst_status_top
  import dspst_pkg::*;
#(
  parameter int ACC_EXT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           view_sel,
  input  logic                 wr_req,
  input  logic [15:0]          wr_data,
  output logic [15:0]          rd_data,
  input  logic                 store_req,
  input  logic                 restore_req,
  input  logic                 swap_req,
  input  logic [2:0]           irq_pend,
  input  logic [1:0]           user_in,
  input  logic [3:0]           cond_sel,
  output logic                 cond_pass,
  output logic [ACC_EXT_W-1:0] acc0_ext,
  output logic [ACC_EXT_W-1:0] acc1_ext
);

  localparam int NUM_ACC = 2;

  view_e  view;
  flags_t flag_live, flag_shadow, flag_next;
  modes_t mode_live, mode_shadow, mode_next;
  logic   flag_wr_en, mode_wr_en;
  logic   store_evt, restore_evt, swap_evt;
  logic [1:0]                     acc_wr_en;
  logic [NIB_W-1:0]               acc_nib;
  logic [NUM_ACC*ACC_EXT_W-1:0]   acc_flat;

  assign view        = view_e'(view_sel);
  assign store_evt   = store_req;
  assign restore_evt = restore_req;
  assign swap_evt    = swap_req;

  dspst_view_port u_view (
    .view       (view),
    .wr_req     (wr_req),
    .wr_data    (wr_data),
    .flags      (flag_live),
    .modes      (mode_live),
    .nib0       (acc0_ext[NIB_W-1:0]),
    .nib1       (acc1_ext[NIB_W-1:0]),
    .pend       (irq_pend),
    .uin        (user_in),
    .rd_data    (rd_data),
    .flag_wr_en (flag_wr_en),
    .flag_next  (flag_next),
    .mode_wr_en (mode_wr_en),
    .mode_next  (mode_next),
    .acc_wr_en  (acc_wr_en),
    .acc_nib    (acc_nib)
  );

  dspst_flag_bank u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (flag_wr_en),
    .wr_val  (flag_next),
    .store   (store_evt),
    .restore (restore_evt),
    .live    (flag_live),
    .shadow  (flag_shadow)
  );

  dspst_mode_bank u_modes (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (mode_wr_en),
    .wr_val (mode_next),
    .swap   (swap_evt),
    .live   (mode_live),
    .shadow (mode_shadow)
  );

  dspst_acc_ext #(.NUM_ACC(NUM_ACC), .EXT_W(ACC_EXT_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (acc_wr_en),
    .nib      (acc_nib),
    .ext_flat (acc_flat)
  );

  assign acc0_ext  = acc_flat[0 +: ACC_EXT_W];
  assign acc1_ext  = acc_flat[ACC_EXT_W +: ACC_EXT_W];
  assign cond_pass = cond_check(cond_sel, flag_live, user_in);

endmodule

// File: rtl/dspst_status_chk.sv
module dspst_status_chk
  import dspst_pkg::*;
#(
  parameter int EXT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             store_evt,
  input logic             restore_evt,
  input logic             swap_evt,
  input logic             mode_wr_en,
  input flags_t           flag_live,
  input flags_t           flag_shadow,
  input modes_t           mode_live,
  input modes_t           mode_shadow,
  input logic [2:0]       view_sel,
  input logic [15:0]      rd_data,
  input logic [3:0]       cond_sel,
  input logic             cond_pass,
  input logic [EXT_W-1:0] acc0_ext,
  input logic [EXT_W-1:0] acc1_ext
);

  localparam int HI_W = EXT_W - 3;

  // R7
  store_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt |=> flag_shadow == $past(flag_live));

  // R8
  restore_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_evt |=> flag_live == $past(flag_shadow));

  // R8
  restore_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_evt && !store_evt) |=> $stable(flag_shadow));

  // R9
  swap_xchg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> (mode_live == $past(mode_shadow)) && (mode_shadow == $past(mode_live)));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!swap_evt && !mode_wr_en) |=> $stable(mode_live) && $stable(mode_shadow));

  // R4
  acc_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(acc0_ext[EXT_W-1:3]) == 0 || $countones(acc0_ext[EXT_W-1:3]) == HI_W) &&
    ($countones(acc1_ext[EXT_W-1:3]) == 0 || $countones(acc1_ext[EXT_W-1:3]) == HI_W));

  // R6
  rsv_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (view_sel >= 3'd5) |-> rd_data == 16'h0000);

  // R11
  cond_gt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 4'd3) |-> cond_pass == (!flag_live.zero && !flag_live.minus));

endmodule

bind dspst_status_top dspst_status_chk #(.EXT_W(ACC_EXT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .store_evt   (store_evt),
  .restore_evt (restore_evt),
  .swap_evt    (swap_evt),
  .mode_wr_en  (mode_wr_en),
  .flag_live   (flag_live),
  .flag_shadow (flag_shadow),
  .mode_live   (mode_live),
  .mode_shadow (mode_shadow),
  .view_sel    (view_sel),
  .rd_data     (rd_data),
  .cond_sel    (cond_sel),
  .cond_pass   (cond_pass),
  .acc0_ext    (acc0_ext),
  .acc1_ext    (acc1_ext)
);

// File: tb/dspst_status_top_tb_top.sv
`timescale 1ns/1ps
module dspst_status_top_tb_top;

  localparam int EW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  view_sel = '0;
  logic        wr_req = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        store_req = 1'b0, restore_req = 1'b0, swap_req = 1'b0;
  logic [2:0]  irq_pend = '0;
  logic [1:0]  user_in = '0;
  logic [3:0]  cond_sel = '0;
  logic        cond_pass;
  logic [EW-1:0] acc0_ext, acc1_ext;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dspst_status_top #(.ACC_EXT_W(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .view_sel(view_sel), .wr_req(wr_req),
    .wr_data(wr_data), .rd_data(rd_data), .store_req(store_req),
    .restore_req(restore_req), .swap_req(swap_req), .irq_pend(irq_pend),
    .user_in(user_in), .cond_sel(cond_sel), .cond_pass(cond_pass),
    .acc0_ext(acc0_ext), .acc1_ext(acc1_ext)
  );

  // bench model; flag bits: 0 zero,1 minus,2 norm,3 ovf,4 ext,5 c0,6 c1,7 slat,8 lovf,9 arz
  // mode bits: 0 sat,1 sata,3:2 hwm,4 shm,6:5 ps0,8:7 ps1,16:9 page,17 stp16,18 cmd,
  //            19 epi,20 epj,28:21 modulo,36:29 bitrev,39:37 imen
  logic [9:0]    f, fs;
  logic [39:0]   m, ms;
  logic [EW-1:0] a0, a1;

  function automatic logic [15:0] exp_read(logic [2:0] v, logic [2:0] p, logic [1:0] u);
    case (v)
      3'd0: return {6'b0, f};
      3'd1: return {a0[3:0], m[39:37], m[0], f[9], f[4], f[7] | f[8], f[5], f[3], f[2], f[1], f[0]};
      3'd2: return {a1[3:0], 1'b0, m[4], m[6:5], m[16:9]};
      3'd3: return {p[1], p[0], p[2], 1'b0, u[1], u[0], m[8:7], m[20], m[19], m[18], m[17],
                    m[1], m[0], m[3:2]};
      3'd4: return {m[36:29], m[28:21]};
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic exp_cond(logic [3:0] c, logic [1:0] u);
    case (c)
      4'd0: return 1'b1;
      4'd1: return f[0];
      4'd2: return ~f[0];
      4'd3: return ~f[0] & ~f[1];
      4'd4: return ~f[1];
      4'd5: return f[1];
      4'd6: return f[1] | f[0];
      4'd7: return ~f[2];
      4'd8: return f[5];
      4'd9: return f[3];
      4'd10: return f[4];
      4'd11: return f[7] | f[8];
      4'd12: return ~f[9];
      4'd13: return ~u[0];
      4'd14: return u[0];
      default: return u[1];
    endcase
  endfunction

  function automatic logic [EW-1:0] sx(logic [3:0] n);
    return {{(EW-4){n[3]}}, n};
  endfunction

  task automatic model_step(logic [2:0] v, logic [15:0] d, logic we, logic st, logic rs, logic sw);
    logic [9:0]    nf  = f;
    logic [9:0]    nfs = fs;
    logic [39:0]   nm  = m;
    logic [39:0]   nms = ms;
    if (we) begin
      case (v)
        3'd0: nf = d[9:0];
        3'd1: begin
          nf[0] = d[0]; nf[1] = d[1]; nf[2] = d[2]; nf[3] = d[3]; nf[5] = d[4];
          nf[7] = d[5]; nf[8] = d[5]; nf[4] = d[6]; nf[9] = d[7];
          nm[0] = d[8]; nm[39:37] = d[11:9];
          a0 = sx(d[15:12]);
        end
        3'd2: begin
          nm[16:9] = d[7:0]; nm[6:5] = d[9:8]; nm[4] = d[10];
          a1 = sx(d[15:12]);
        end
        3'd3: begin
          nm[3:2] = d[1:0]; nm[0] = d[2]; nm[1] = d[3]; nm[17] = d[4];
          nm[18] = d[5]; nm[19] = d[6]; nm[20] = d[7]; nm[8:7] = d[9:8];
        end
        3'd4: begin
          nm[28:21] = d[7:0]; nm[36:29] = d[15:8];
        end
        default: ;
      endcase
    end
    if (rs) nf = fs;
    if (st) nfs = f;
    if (sw) begin
      nm  = ms;
      nms = m;
    end
    f = nf; fs = nfs; m = nm; ms = nms;
  endtask

  task automatic check16(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string view_tag(logic [2:0] v);
    case (v)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd3: return "R5";
      3'd2, 3'd4: return "R12";
      default: return "R6";
    endcase
  endfunction

  // drives at the falling edge, checks combinational outputs 1 ns later, model advances at the rising edge
  task automatic cyc(string tag, logic [2:0] v, logic [15:0] d, logic we,
                     logic st, logic rs, logic sw, logic [2:0] p, logic [1:0] u, logic [3:0] c);
    @(negedge clk);
    view_sel = v; wr_data = d; wr_req = we; store_req = st; restore_req = rs;
    swap_req = sw; irq_pend = p; user_in = u; cond_sel = c;
    #1;
    check16((tag == "") ? view_tag(v) : tag, rd_data, exp_read(v, p, u));
    check16("R11", {15'b0, cond_pass}, {15'b0, exp_cond(c, u)});
    check16("R4", {{(16-EW){1'b0}}, acc0_ext}, {{(16-EW){1'b0}}, a0});
    check16("R4", {{(16-EW){1'b0}}, acc1_ext}, {{(16-EW){1'b0}}, a1});
    @(posedge clk);
    model_step(v, d, we, st, rs, sw);
  endtask

  task automatic rd(string tag, logic [2:0] v);
    cyc(tag, v, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b0, 2'b0, 4'd0);
  endtask

  task automatic wr(string tag, logic [2:0] v, logic [15:0] d);
    cyc(tag, v, d, 1'b1, 1'b0, 1'b0, 1'b0, 3'b0, 2'b0, 4'd0);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    f = '0; fs = '0; ms = '0; a0 = '0; a1 = '0;
    m = '0; m[1] = 1'b1; m[18] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state against literal values
    @(negedge clk);
    view_sel = 3'd3; #1;
    check16("R1", rd_data, 16'h0028);
    view_sel = 3'd0; #1;
    check16("R1", rd_data, 16'h0000);
    check16("R1", {acc1_ext, acc0_ext}, 16'h0000);
    rd("R1", 3'd1); rd("R1", 3'd2); rd("R1", 3'd4);

    // R3 alias bit both ways
    wr("R3", 3'd1, 16'h0020);
    rd("R3", 3'd0);
    wr("R3", 3'd0, 16'h0100);
    rd("R3", 3'd1);
    wr("R3", 3'd0, 16'h0040);
    wr("R3", 3'd1, 16'h0000);
    rd("R3", 3'd0);

    // R4 sign extension of both accumulators
    wr("R4", 3'd2, 16'h8000);
    rd("R4", 3'd2);
    wr("R4", 3'd1, 16'h7000);
    rd("R4", 3'd1);
    wr("R4", 3'd2, 16'hF5A5);
    rd("R12", 3'd2);

    // R5 read-only fields and pending order
    wr("R5", 3'd3, 16'hFFFF);
    rd("R5", 3'd3);
    cyc("R5", 3'd3, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b100, 2'b00, 4'd0);
    cyc("R5", 3'd3, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b001, 2'b00, 4'd0);
    cyc("R5", 3'd3, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b010, 2'b01, 4'd14);
    cyc("R5", 3'd3, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 2'b10, 4'd15);

    // R6 reserved views
    for (int v = 5; v < 8; v++) wr("R6", 3'(v), 16'hFFFF);
    for (int v = 0; v < 8; v++) rd("R6", 3'(v));

    // R7 / R8 store, restore, shadow kept
    wr("R7", 3'd0, 16'h02AA);
    cyc("R7", 3'd0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b0, 2'b0, 4'd0);
    wr("R7", 3'd0, 16'h0155);
    rd("R7", 3'd0);
    cyc("R8", 3'd0, 16'h03FF, 1'b1, 1'b0, 1'b1, 1'b0, 3'b0, 2'b0, 4'd0);
    rd("R8", 3'd0);
    wr("R8", 3'd0, 16'h0155);
    cyc("R8", 3'd0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b0, 2'b0, 4'd0);
    rd("R8", 3'd0);
    // store and restore together exchange
    wr("R8", 3'd0, 16'h0155);
    cyc("R8", 3'd0, 16'h0, 1'b0, 1'b1, 1'b1, 1'b0, 3'b0, 2'b0, 4'd0);
    rd("R8", 3'd0);
    cyc("R8", 3'd0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b0, 2'b0, 4'd0);
    rd("R8", 3'd0);

    // R9 swap, write collision dropped
    wr("R9", 3'd4, 16'h1234);
    cyc("R9", 3'd4, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b0, 2'b0, 4'd0);
    rd("R9", 3'd4);
    rd("R9", 3'd3);
    cyc("R9", 3'd4, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 3'b0, 2'b0, 4'd0);
    rd("R9", 3'd4);
    rd("R9", 3'd3);

    // R10 swap together with store and restore
    wr("R10", 3'd0, 16'h0321);
    cyc("R10", 3'd0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b1, 3'b0, 2'b0, 4'd0);
    wr("R10", 3'd0, 16'h0000);
    cyc("R10", 3'd4, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1, 3'b0, 2'b0, 4'd0);
    rd("R10", 3'd0);
    rd("R10", 3'd4);

    // R11 every condition code on a few flag patterns
    for (int k = 0; k < 4; k++) begin
      wr("R11", 3'd0, 16'((k * 16'h0137) & 16'h03FF));
      for (int c = 0; c < 16; c++)
        cyc("R11", 3'd0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b0, 2'(k), 4'(c));
    end

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc("", 3'(r[2:0]), 16'($urandom), r[3] | r[4],
          (r[7:5] == 3'd0), (r[10:8] == 3'd0), (r[13:11] == 3'd0),
          3'(r[16:14]), 2'(r[18:17]), 4'(r[22:19]));
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule